// File: doc/BRIEF.md
# Slave-Mode Timer Counter Controller

This block is an up/down timer counter whose advance and reload are governed by a three-bit slave-mode code. The counter can run on every system clock, follow a two-channel quadrature encoder in three decoding variants, or respond to a single trigger line. On the trigger line it can restart, gate, start, or clock the counter. When the counter is up-counting it wraps from the reload value to zero. When it is down-counting it wraps from zero to the reload value. Each wrap and each restart raises a one-cycle update pulse.

All three external lines (encoder A, encoder B, trigger) cross into the system clock domain through a synchroniser chain before their edges are detected. A start or restart request also produces a one-cycle trigger pulse for a downstream timer. When the master-sync enable is set, the block holds back its own start or restart by a fixed number of cycles, so that the downstream timer starts in step with it.

Mode encoding (field `mode_sel`): 000 free-run, 001 encoder on A edges, 010 encoder on B edges, 011 encoder on both edges, 100 restart, 101 gate, 110 start, 111 edge clock.

Top module: `tmr_slave_ctrl`

## Requirements
- R1: While `rst_n` is low and directly after it is released, `count` is 0 and `upd_evt`, `trig_out` and `dir_out` are 0.
- R2: In mode 000 the counter changes by exactly one on every clock: up when `dir_down`=0 and down when `dir_down`=1. Any change that is not a wrap or a load is a step of exactly one.
- R3: An up-count at or above `reload` gives 0, and a down-count at 0 gives `reload`. Each such wrap raises `upd_evt` for exactly one cycle.
- R4: In mode 001 only A edges count. Edges on B and on the trigger have no effect. A rising edge of A counts up when B is low and down when B is high. A falling edge of A counts up when B is high and down when B is low.
- R5: In mode 010 only B edges count. A rising edge of B counts up when A is high. A falling edge of B counts up when A is low. The opposite levels count down.
- R6: In mode 011 edges on both channels count, giving four counts per encoder period. `dir_out` is 1 after a down count and 0 after an up count.
- R7: In mode 100 the counter runs on every clock. A trigger rising edge loads 0 when `dir_down`=0 and loads `reload` when `dir_down`=1, and it raises `upd_evt`. If the restart falls in the same cycle as a wrap, only a single `upd_evt` pulse is produced.
- R8: In mode 101 the counter advances only while the synchronised trigger is high. When the trigger goes low, the counter holds its value and is not cleared.
- R9: In mode 110 the counter stays idle until a trigger rising edge. It then runs from its present value, and a later falling edge does not stop it.
- R10: In mode 111 the counter advances by one per trigger rising edge, and by nothing while the trigger stays high or low.
- R11: A change on any external line affects the counter at the third rising clock edge after the change.
- R12: `trig_out` pulses for one cycle on each accepted start or restart request. When `sync_en`=1, the counter acts on the request `SYNC_DLY` (default 2) cycles after that pulse instead of in the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| mode_sel | input | 3 | Slave-mode code |
| enc_a | input | 1 | Encoder channel A, asynchronous |
| enc_b | input | 1 | Encoder channel B, asynchronous |
| trig_in | input | 1 | Trigger line, asynchronous |
| reload | input | CNT_W | Wrap and restart value |
| dir_down | input | 1 | Direction outside encoder modes (1 = down) |
| sync_en | input | 1 | Delay own start or restart for alignment with a downstream timer |
| count | output | CNT_W | Counter value |
| dir_out | output | 1 | Current counting direction |
| upd_evt | output | 1 | One-cycle update pulse on wrap or restart |
| trig_out | output | 1 | One-cycle start pulse toward a downstream timer |

## Verification
In restart mode the counter runs freely, so a trigger restart and a natural wrap can land on the same clock edge. The bench provokes this by lowering `reload` and raising the trigger exactly two counts before the counter reaches `reload`. With the synchroniser latency, the restart then coincides with the wrap edge. The result is judged by the counter reading 0 after that edge, `upd_evt` being high for that one cycle only, and the count stepping to 1 on the following edge.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

   typedef enum logic [2:0] {
      SM_FREE    = 3'b000,
      SM_QA      = 3'b001,
      SM_QB      = 3'b010,
      SM_QAB     = 3'b011,
      SM_RESTART = 3'b100,
      SM_GATE    = 3'b101,
      SM_START   = 3'b110,
      SM_EDGE    = 3'b111
   } slave_mode_e;

   localparam int unsigned CH_A   = 0;
   localparam int unsigned CH_B   = 1;
   localparam int unsigned CH_TRG = 2;
   localparam int unsigned N_CH   = 3;

endpackage

// File: rtl/tsc_edge_sync.sv
module tsc_edge_sync #(
   parameter int unsigned N      = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] din_i,
   output logic [N-1:0] lvl_o,
   output logic [N-1:0] rise_o,
   output logic [N-1:0] fall_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tsc_edge_sync: STAGES must be at least 2");
   end

   for (genvar c = 0; c < N; c++) begin : g_ch
      logic [STAGES:0] sh_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            sh_q <= '0;
         end else begin
            sh_q[0] <= din_i[c];
            for (int i = 1; i <= STAGES; i++) begin
               sh_q[i] <= sh_q[i-1];
            end
         end
      end

      assign lvl_o[c]  = sh_q[STAGES-1];
      assign rise_o[c] = sh_q[STAGES-1] & ~sh_q[STAGES];
      assign fall_o[c] = ~sh_q[STAGES-1] & sh_q[STAGES];
   end

endmodule

// File: rtl/tsc_mode_ctl.sv
module tsc_mode_ctl
   import tsc_pkg::*;
#(
   parameter int unsigned SYNC_DLY = 2
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [2:0]      mode_i,
   input  logic [N_CH-1:0] lvl_i,
   input  logic [N_CH-1:0] rise_i,
   input  logic [N_CH-1:0] fall_i,
   input  logic            dir_down_i,
   input  logic            sync_en_i,
   output logic            cnt_en_o,
   output logic            cnt_dn_o,
   output logic            restart_o,
   output logic            trig_o,
   output logic            dir_o
);

   if (SYNC_DLY < 1) begin : g_bad_dly
      $error("tsc_mode_ctl: SYNC_DLY must be at least 1");
   end

   slave_mode_e md;
   assign md = slave_mode_e'(mode_i);

   // quadrature direction decode; A leading B counts up
   logic a_up, a_dn, b_up, b_dn, a_ev, b_ev;
   assign a_up = (rise_i[CH_A] & ~lvl_i[CH_B]) | (fall_i[CH_A] &  lvl_i[CH_B]);
   assign a_dn = (rise_i[CH_A] &  lvl_i[CH_B]) | (fall_i[CH_A] & ~lvl_i[CH_B]);
   assign b_up = (rise_i[CH_B] &  lvl_i[CH_A]) | (fall_i[CH_B] & ~lvl_i[CH_A]);
   assign b_dn = (rise_i[CH_B] & ~lvl_i[CH_A]) | (fall_i[CH_B] &  lvl_i[CH_A]);
   assign a_ev = a_up | a_dn;
   assign b_ev = b_up | b_dn;

   logic quad;
   assign quad = (md == SM_QA) || (md == SM_QB) || (md == SM_QAB);

   // start / restart request and its alignment delay
   logic run_q;
   logic start_req;
   assign start_req = rise_i[CH_TRG] &
                      ((md == SM_RESTART) || ((md == SM_START) && !run_q));
   assign trig_o = start_req;

   logic [SYNC_DLY-1:0] dly_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         dly_q <= '0;
      end else begin
         dly_q[0] <= start_req;
         for (int i = 1; i < SYNC_DLY; i++) begin
            dly_q[i] <= dly_q[i-1];
         end
      end
   end

   logic start_eff, start_go;
   assign start_eff = sync_en_i ? dly_q[SYNC_DLY-1] : start_req;
   assign start_go  = start_eff && (md == SM_START);
   assign restart_o = start_eff && (md == SM_RESTART);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            run_q <= 1'b0;
      else if (md != SM_START) run_q <= 1'b0;
      else if (start_go)       run_q <= 1'b1;
   end

   always_comb begin
      cnt_en_o = 1'b0;
      cnt_dn_o = dir_down_i;
      case (md)
         SM_FREE:    cnt_en_o = 1'b1;
         SM_QA: begin
            cnt_en_o = a_ev;
            cnt_dn_o = a_dn;
         end
         SM_QB: begin
            cnt_en_o = b_ev;
            cnt_dn_o = b_dn;
         end
         SM_QAB: begin
            cnt_en_o = a_ev ^ b_ev;
            cnt_dn_o = a_ev ? a_dn : b_dn;
         end
         SM_RESTART: cnt_en_o = 1'b1;
         SM_GATE:    cnt_en_o = lvl_i[CH_TRG];
         SM_START:   cnt_en_o = run_q | start_go;
         SM_EDGE:    cnt_en_o = rise_i[CH_TRG];
         default:    cnt_en_o = 1'b0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               dir_o <= 1'b0;
      else if (!quad)            dir_o <= dir_down_i;
      else if (cnt_en_o)         dir_o <= cnt_dn_o;
   end

   // R9
   run_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (md == SM_START && run_q && fall_i[CH_TRG] && mode_i == $past(mode_i)) |=> run_q);

endmodule

// File: rtl/tsc_counter.sv
module tsc_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             dn_i,
   input  logic             restart_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic [CNT_W-1:0] count_o,
   output logic             upd_o
);

   if (CNT_W < 2) begin : g_bad_w
      $error("tsc_counter: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] count_q;
   logic             upd_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         count_q <= '0;
         upd_q   <= 1'b0;
      end else begin
         upd_q <= 1'b0;
         if (restart_i) begin
            count_q <= dn_i ? reload_i : '0;
            upd_q   <= 1'b1;
         end else if (en_i) begin
            if (dn_i) begin
               if (count_q == '0) begin
                  count_q <= reload_i;
                  upd_q   <= 1'b1;
               end else begin
                  count_q <= count_q - 1'b1;
               end
            end else begin
               if (count_q >= reload_i) begin
                  count_q <= '0;
                  upd_q   <= 1'b1;
               end else begin
                  count_q <= count_q + 1'b1;
               end
            end
         end
      end
   end

   assign count_o = count_q;
   assign upd_o   = upd_q;

   // R3
   upd_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_q |-> (count_q == '0 || count_q == $past(reload_i)));

   // R2
   unit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!upd_q && count_q != $past(count_q)) |->
      (count_q == $past(count_q) + 1'b1 || count_q == $past(count_q) - 1'b1));

endmodule

// File: rtl/tmr_slave_ctrl.sv
module tmr_slave_ctrl
   import tsc_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned SYNC_DLY    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       mode_sel,
   input  logic             enc_a,
   input  logic             enc_b,
   input  logic             trig_in,
   input  logic [CNT_W-1:0] reload,
   input  logic             dir_down,
   input  logic             sync_en,
   output logic [CNT_W-1:0] count,
   output logic             dir_out,
   output logic             upd_evt,
   output logic             trig_out
);

   logic [N_CH-1:0] raw, lvl, rise, fall;
   assign raw = {trig_in, enc_b, enc_a};

   logic cnt_en, cnt_dn, restart;

   tsc_edge_sync #(
      .N      (N_CH),
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk_i  (clk),
      .rst_ni (rst_n),
      .din_i  (raw),
      .lvl_o  (lvl),
      .rise_o (rise),
      .fall_o (fall)
   );

   tsc_mode_ctl #(
      .SYNC_DLY (SYNC_DLY)
   ) i_ctl (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .mode_i     (mode_sel),
      .lvl_i      (lvl),
      .rise_i     (rise),
      .fall_i     (fall),
      .dir_down_i (dir_down),
      .sync_en_i  (sync_en),
      .cnt_en_o   (cnt_en),
      .cnt_dn_o   (cnt_dn),
      .restart_o  (restart),
      .trig_o     (trig_out),
      .dir_o      (dir_out)
   );

   tsc_counter #(
      .CNT_W (CNT_W)
   ) i_cnt (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .en_i      (cnt_en),
      .dn_i      (cnt_dn),
      .restart_i (restart),
      .reload_i  (reload),
      .count_o   (count),
      .upd_o     (upd_evt)
   );

   // R8
   gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == SM_GATE && !lvl[CH_TRG]) |=> $stable(count));

   // R10
   edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == SM_EDGE && !rise[CH_TRG]) |=> $stable(count));

   // R7
   restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && !dir_down) |=> (count == '0 && upd_evt));

   // R12
   trig_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out |-> (mode_sel == SM_RESTART || mode_sel == SM_START));

endmodule

// File: tb/test_tmr_slave_ctrl.sv
module test_tmr_slave_ctrl;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [2:0]   mode_sel = 3'b000;
   logic         enc_a = 1'b0, enc_b = 1'b0, trig_in = 1'b0;
   logic [W-1:0] reload = 16'hFFFF;
   logic         dir_down = 1'b0, sync_en = 1'b0;
   logic [W-1:0] count;
   logic         dir_out, upd_evt, trig_out;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tmr_slave_ctrl i_tmr_slave_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_sel (mode_sel),
      .enc_a    (enc_a),
      .enc_b    (enc_b),
      .trig_in  (trig_in),
      .reload   (reload),
      .dir_down (dir_down),
      .sync_en  (sync_en),
      .count    (count),
      .dir_out  (dir_out),
      .upd_evt  (upd_evt),
      .trig_out (trig_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(input logic [2:0] m, input logic [W-1:0] rl, input logic dn);
      @(negedge clk);
      rst_n = 1'b0;
      mode_sel = m; reload = rl; dir_down = dn;
      enc_a = 0; enc_b = 0; trig_in = 0; sync_en = 0;
      tick(2);
      rst_n = 1'b1;
   endtask

   task automatic enc(input logic a, input logic b);
      enc_a = a; enc_b = b;
      tick(4);
   endtask

   task automatic t_reset;
      @(negedge clk);
      rst_n = 1'b0; mode_sel = 3'b000;
      tick(2);
      chk("R1 count in reset", count, 0);
      chk("R1 upd in reset", upd_evt, 0);
      chk("R1 trig in reset", trig_out, 0);
      chk("R1 dir in reset", dir_out, 0);
      rst_n = 1'b1;
      chk("R1 count after release", count, 0);
   endtask

   task automatic t_free;
      int v;
      do_reset(3'b000, 16'hFFFF, 1'b0);
      tick(3);
      for (int i = 0; i < 4; i++) begin
         v = count; tick(1);
         chk("R2 up step", count, v + 1);
      end
      dir_down = 1'b1;
      v = count; tick(1);
      chk("R2 down step", count, v - 1);
   endtask

   task automatic t_wrap;
      do_reset(3'b000, 16'd5, 1'b0);
      tick(5);
      chk("R3 at reload", count, 5);
      chk("R3 no upd before wrap", upd_evt, 0);
      tick(1);
      chk("R3 up wrap to 0", count, 0);
      chk("R3 upd on up wrap", upd_evt, 1);
      tick(1);
      chk("R3 upd one cycle", upd_evt, 0);
      do_reset(3'b000, 16'd5, 1'b1);
      tick(1);
      chk("R3 down wrap to reload", count, 5);
      chk("R3 upd on down wrap", upd_evt, 1);
      tick(1);
      chk("R3 down after wrap", count, 4);
   endtask

   task automatic t_quad_a;
      do_reset(3'b001, 16'hFFFF, 1'b0);
      tick(1);
      enc_a = 1'b1;
      tick(2);
      chk("R11 no change after two edges", count, 0);
      tick(1);
      chk("R11 change at third edge", count, 1);
      tick(1);
      enc(1, 1);
      chk("R4 B edge ignored", count, 1);
      trig_in = 1'b1; tick(4);
      chk("R4 trigger ignored", count, 1);
      trig_in = 1'b0; tick(4);
      enc(0, 1);
      chk("R4 A fall with B high counts up", count, 2);
      chk("R4 dir up", dir_out, 0);
      enc(1, 1);
      chk("R4 A rise with B high counts down", count, 1);
      chk("R4 dir down", dir_out, 1);
      enc(1, 0);
      enc(0, 0);
      chk("R4 A fall with B low counts down", count, 0);
   endtask

   task automatic t_quad_b;
      do_reset(3'b010, 16'hFFFF, 1'b0);
      tick(1);
      enc(1, 0);
      chk("R5 A edge ignored", count, 0);
      enc(1, 1);
      enc(0, 1);
      enc(0, 0);
      chk("R5 up cycle two counts", count, 2);
      enc(0, 1);
      chk("R5 B rise with A low counts down", count, 1);
   endtask

   task automatic t_quad_ab;
      do_reset(3'b011, 16'hFFFF, 1'b0);
      tick(1);
      enc(1, 0); enc(1, 1); enc(0, 1); enc(0, 0);
      chk("R6 four counts per cycle", count, 4);
      chk("R6 dir up", dir_out, 0);
      enc(0, 1); enc(1, 1); enc(1, 0);
      chk("R6 reverse three counts", count, 1);
      chk("R6 dir down", dir_out, 1);
      enc(0, 0);
      chk("R6 reverse full cycle", count, 0);
   endtask

   task automatic t_restart;
      do_reset(3'b100, 16'd100, 1'b0);
      tick(20);
      chk("R7 free run", count, 20);
      trig_in = 1'b1;
      tick(2);
      chk("R12 trig pulse restart", trig_out, 1);
      tick(1);
      chk("R7 restart up loads 0", count, 0);
      chk("R7 restart upd", upd_evt, 1);
      trig_in = 1'b0;
      do_reset(3'b100, 16'd100, 1'b1);
      tick(10);
      chk("R7 down run", count, 91);
      trig_in = 1'b1;
      tick(3);
      chk("R7 restart down loads reload", count, 100);
      chk("R7 restart down upd", upd_evt, 1);
      trig_in = 1'b0;
      // coincident restart and wrap
      do_reset(3'b100, 16'd30, 1'b0);
      tick(28);
      trig_in = 1'b1;
      tick(2);
      chk("R7 at reload before coincidence", count, 30);
      tick(1);
      chk("R7 coincident result", count, 0);
      chk("R7 coincident upd", upd_evt, 1);
      tick(1);
      chk("R7 single upd pulse", upd_evt, 0);
      chk("R7 runs on after coincidence", count, 1);
      trig_in = 1'b0;
   endtask

   task automatic t_gate;
      do_reset(3'b101, 16'hFFFF, 1'b0);
      tick(5);
      chk("R8 idle while low", count, 0);
      trig_in = 1'b1;
      tick(8);
      trig_in = 1'b0;
      tick(6);
      chk("R8 counts high cycles", count, 8);
      tick(5);
      chk("R8 holds not reset", count, 8);
   endtask

   task automatic t_start;
      do_reset(3'b110, 16'hFFFF, 1'b0);
      tick(5);
      chk("R9 idle before start", count, 0);
      trig_in = 1'b1;
      tick(2);
      chk("R12 trig pulse start", trig_out, 1);
      chk("R9 not yet started", count, 0);
      tick(1);
      chk("R9 started", count, 1);
      trig_in = 1'b0;
      tick(10);
      chk("R9 fall does not stop", count, 11);
      trig_in = 1'b1;
      tick(2);
      chk("R12 no pulse while running", trig_out, 0);
      trig_in = 1'b0;
   endtask

   task automatic t_edge;
      do_reset(3'b111, 16'hFFFF, 1'b0);
      for (int i = 0; i < 3; i++) begin
         trig_in = 1'b1; tick(6);
         trig_in = 1'b0; tick(3);
      end
      chk("R10 one per rising edge", count, 3);
   endtask

   task automatic t_sync;
      do_reset(3'b110, 16'hFFFF, 1'b0);
      sync_en = 1'b1;
      tick(2);
      trig_in = 1'b1;
      tick(2);
      chk("R12 trig pulse with sync", trig_out, 1);
      tick(1);
      chk("R12 delayed start 1", count, 0);
      chk("R12 trig one cycle", trig_out, 0);
      tick(1);
      chk("R12 delayed start 2", count, 0);
      tick(1);
      chk("R12 start after delay", count, 1);
      trig_in = 1'b0;
   endtask

   initial begin
      tick(1);
      t_reset();
      t_free();
      t_wrap();
      t_quad_a();
      t_quad_b();
      t_quad_ab();
      t_restart();
      t_gate();
      t_start();
      t_edge();
      t_sync();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule